// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Request Unit

This unit sits between five interrupt request lines and a CPU core. One line is a non-maskable trap. Three are maskable restart requests, each with a fixed vector. The fifth is a maskable external request whose handler address comes from the requesting device. The unit keeps a global interrupt-enable flag and a mask bit for each restart line. It latches a rising edge on the highest restart line. It qualifies the trap line so that a glitch cannot fire it.

The CPU pulses `sample` at an instruction boundary. If any request is eligible at that edge, the unit latches the winner and offers it: either the winner's 16-bit vector, or a flag saying the address must come from the device. The offer is held until the CPU pulses `ack`. The ack clears the state that belongs to the serviced source.

The offer logic is a two-state machine. In IDLE, a `sample` pulse with an eligible request takes the TAKE transition to OFFER. In OFFER, an `ack` takes the RELEASE transition back to IDLE. The trap qualifier is a three-state machine:
- WAIT_LOW moves to ARMED when the line is low.
- ARMED moves to READY when the line is high.
- READY drops back to ARMED when the line goes low.
- An ack of the trap forces WAIT_LOW from any state.

Top module: `irq_arbiter`

## Requirements
- R1: After reset, `irq_valid` is 0 and `status` reads 8'h07. Status fields: bits[2:0] are the masks for the low, middle and high restart lines; bit3 is the global enable; bit4 and bit5 are the live levels of `vec0_req` and `vec1_req`; bit6 is the pending latch of `vec2_req`; bit7 is 0.
- R2: `ie_set` sets the global enable. `ie_clr` clears it and wins when both strobes arrive together.
- R3: On `cmd_wr`, when `cmd_data[3]` is 1, the masks load from `cmd_data[2:0]`, where bit n masks restart line n and a 1 means masked. When `cmd_data[3]` is 0, the masks keep their old value.
- R4: On `cmd_wr`, when `cmd_data[4]` is 1, the `vec2_req` pending latch clears. This happens whatever the value of `cmd_data[3]`.
- R5: A rising edge on `vec2_req` sets its pending latch, which stays set after the line falls. A line that stays high does not set the latch again.
- R6: `vec1_req` and `vec0_req` are eligible only while high at the sampling edge, unmasked, and with the global enable set.
- R7: The trap is eligible only after the line has been seen low and then high, and only while it stays high. Neither the enable nor the masks gate it. After its ack, the line must go low and then high again before the trap is eligible again.
- R8: Fixed priority: trap > `vec2_req` > `vec1_req` > `vec0_req` > `ext_req`.
- R9: Offered vectors: trap 16'h0024, `vec2_req` 16'h003C, `vec1_req` 16'h0034, `vec0_req` 16'h002C. An `ext_req` offer sets `irq_nonvec` and drives vector 16'h0000.
- R10: A `sample` pulse with an eligible request raises `irq_valid` after that edge. The offer holds until `ack`. A `sample` during an offer and an `ack` with no offer are both ignored.
- R11: An ack of any maskable source clears the global enable, and this wins over `ie_set`. An ack of the trap leaves the enable unchanged. An ack of `vec2_req` clears its pending latch.
- R12: `ext_req` is gated by the global enable only, never by the masks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_req | input | 1 | Non-maskable trap line |
| vec2_req | input | 1 | Highest restart line, edge-latched |
| vec1_req | input | 1 | Middle restart line, level |
| vec0_req | input | 1 | Lowest restart line, level |
| ext_req | input | 1 | Non-vectored external request |
| ie_set | input | 1 | Global enable set strobe |
| ie_clr | input | 1 | Global enable clear strobe |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_data | input | CMD_W | Command word: masks [2:0], mask load enable [3], pending clear [4] |
| sample | input | 1 | Instruction-boundary sampling pulse |
| ack | input | 1 | Acknowledge of the current offer |
| irq_valid | output | 1 | An offer is held |
| irq_vector | output | VEC_W | Vector of the offered source |
| irq_nonvec | output | 1 | The offer is the non-vectored request |
| status | output | 8 | Masks, enable, restart line levels and pending latch |

## Verification
The assertions assume that every input is already synchronous to `clk`, and that the strobes `sample`, `ack`, `ie_set`, `ie_clr` and `cmd_wr` are single-cycle pulses. The stimulus changes inputs only just after a falling edge. It holds each strobe high for exactly one rising edge. It drives the trap line through its low and high phases with whole-cycle holds. An ack with no offer is sent on purpose and is legal.

// File: rtl/irq_pkg.sv
package irq_pkg;

    typedef enum logic [2:0] {
        SRC_TRAP = 3'd0,
        SRC_V2   = 3'd1,
        SRC_V1   = 3'd2,
        SRC_V0   = 3'd3,
        SRC_EXT  = 3'd4
    } irq_src_e;

    typedef enum logic [1:0] {
        TQ_WAIT_LOW = 2'd0,
        TQ_ARMED    = 2'd1,
        TQ_READY    = 2'd2
    } tq_state_e;

    typedef enum logic {
        G_IDLE  = 1'b0,
        G_OFFER = 1'b1
    } grant_state_e;

    // Restart numbers are held in tenths; the vector is eight times the number.
    function automatic logic [15:0] vec_of(irq_src_e s);
        int tenths;
        unique case (s)
            SRC_TRAP: tenths = 45;
            SRC_V2:   tenths = 75;
            SRC_V1:   tenths = 65;
            SRC_V0:   tenths = 55;
            default:  tenths = 0;
        endcase
        return 16'((tenths * 8) / 10);
    endfunction

endpackage

// File: rtl/irq_trap_qual.sv
module irq_trap_qual
    import irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic line,
    input  logic clr,
    output logic ready
);

    tq_state_e st, st_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= TQ_WAIT_LOW;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        if (clr) begin
            st_nx = TQ_WAIT_LOW;
        end else begin
            unique case (st)
                TQ_WAIT_LOW: if (!line) st_nx = TQ_ARMED;
                TQ_ARMED:    if (line)  st_nx = TQ_READY;
                TQ_READY:    if (!line) st_nx = TQ_ARMED;
                default:     st_nx = TQ_WAIT_LOW;
            endcase
        end
    end

    assign ready = (st == TQ_READY) && line;

endmodule

// File: rtl/irq_edge_pend.sv
module irq_edge_pend (
    input  logic clk,
    input  logic rst_n,
    input  logic line,
    input  logic clr,
    output logic pend
);

    logic line_q;
    logic rise;

    assign rise = line && !line_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= 1'b0;
            pend   <= 1'b0;
        end else begin
            line_q <= line;
            pend   <= rise || (pend && !clr);
        end
    end

endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs #(
    parameter int NLINE = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ie_set,
    input  logic             ie_clr,
    input  logic             ie_drop,
    input  logic             mask_load,
    input  logic [NLINE-1:0] mask_in,
    output logic             ie,
    output logic [NLINE-1:0] mask
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie   <= 1'b0;
            mask <= '1;
        end else begin
            if (ie_clr || ie_drop) ie <= 1'b0;
            else if (ie_set)       ie <= 1'b1;
            if (mask_load)         mask <= mask_in;
        end
    end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
#(
    parameter int VEC_W = 16,
    parameter int CMD_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nmi_req,
    input  logic             vec2_req,
    input  logic             vec1_req,
    input  logic             vec0_req,
    input  logic             ext_req,
    input  logic             ie_set,
    input  logic             ie_clr,
    input  logic             cmd_wr,
    input  logic [CMD_W-1:0] cmd_data,
    input  logic             sample,
    input  logic             ack,
    output logic             irq_valid,
    output logic [VEC_W-1:0] irq_vector,
    output logic             irq_nonvec,
    output logic [7:0]       status
);

    localparam int NLINE    = 3;
    localparam int MSE_BIT  = NLINE;
    localparam int PCLR_BIT = NLINE + 1;

    grant_state_e gst, gst_nx;
    irq_src_e     cur_src, cur_src_nx;
    irq_src_e     win_src;
    logic         win_any;
    logic         done;

    logic             ie;
    logic [NLINE-1:0] mask;
    logic             pend2;
    logic             trap_rdy;
    logic             e_v2, e_v1, e_v0, e_ext;
    logic             trap_clr, pend_clr, ie_drop;

    // ack of the latched source
    assign done     = (gst == G_OFFER) && ack;
    assign trap_clr = done && (cur_src == SRC_TRAP);
    assign ie_drop  = done && (cur_src != SRC_TRAP);
    assign pend_clr = (done && (cur_src == SRC_V2)) || (cmd_wr && cmd_data[PCLR_BIT]);

    irq_trap_qual u_trap (
        .clk   (clk),
        .rst_n (rst_n),
        .line  (nmi_req),
        .clr   (trap_clr),
        .ready (trap_rdy)
    );

    irq_edge_pend u_pend2 (
        .clk   (clk),
        .rst_n (rst_n),
        .line  (vec2_req),
        .clr   (pend_clr),
        .pend  (pend2)
    );

    irq_ctrl_regs #(.NLINE(NLINE)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .ie_set    (ie_set),
        .ie_clr    (ie_clr),
        .ie_drop   (ie_drop),
        .mask_load (cmd_wr && cmd_data[MSE_BIT]),
        .mask_in   (cmd_data[NLINE-1:0]),
        .ie        (ie),
        .mask      (mask)
    );

    // eligibility and fixed priority
    assign e_v2  = pend2    && !mask[2] && ie;
    assign e_v1  = vec1_req && !mask[1] && ie;
    assign e_v0  = vec0_req && !mask[0] && ie;
    assign e_ext = ext_req  && ie;

    always_comb begin
        win_any = 1'b1;
        win_src = SRC_EXT;
        if (trap_rdy)   win_src = SRC_TRAP;
        else if (e_v2)  win_src = SRC_V2;
        else if (e_v1)  win_src = SRC_V1;
        else if (e_v0)  win_src = SRC_V0;
        else if (e_ext) win_src = SRC_EXT;
        else            win_any = 1'b0;
    end

    // offer state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gst     <= G_IDLE;
            cur_src <= SRC_EXT;
        end else begin
            gst     <= gst_nx;
            cur_src <= cur_src_nx;
        end
    end

    // TAKE and RELEASE transitions
    always_comb begin
        gst_nx     = gst;
        cur_src_nx = cur_src;
        unique case (gst)
            G_IDLE: if (sample && win_any) begin
                gst_nx     = G_OFFER;
                cur_src_nx = win_src;
            end
            G_OFFER: if (ack) gst_nx = G_IDLE;
            default: gst_nx = G_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        irq_valid  = 1'b0;
        irq_vector = '0;
        irq_nonvec = 1'b0;
        unique case (gst)
            G_IDLE: ;
            G_OFFER: begin
                irq_valid  = 1'b1;
                irq_vector = VEC_W'(vec_of(cur_src));
                irq_nonvec = (cur_src == SRC_EXT);
            end
            default: ;
        endcase
    end

    assign status = {1'b0, pend2, vec1_req, vec0_req, ie, mask};

endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk #(
    parameter int VEC_W = 16,
    parameter int CMD_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             vec2_req,
    input logic             ie_clr,
    input logic             cmd_wr,
    input logic [CMD_W-1:0] cmd_data,
    input logic             ack,
    input logic             irq_valid,
    input logic [VEC_W-1:0] irq_vector,
    input logic             irq_nonvec,
    input logic [7:0]       status
);

    a_r10_offer_held: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && !ack) |=> (irq_valid && $stable(irq_vector)));

    a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && ack) |=> !irq_valid);

    a_r9_nonvec_zero: assert property (@(posedge clk) disable iff (!rst_n)
        irq_nonvec |-> (irq_valid && irq_vector == '0));

    a_r11_enable_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && ack && irq_vector != VEC_W'(36)) |=> !status[3]);

    a_r2_clear_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        ie_clr |=> !status[3]);

    a_r4_pend_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_data[4] && !vec2_req) |=> !status[6]);

    a_r3_mask_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !cmd_data[3]) |=> (status[2:0] == $past(status[2:0])));

endmodule

bind irq_arbiter irq_arbiter_chk #(.VEC_W(VEC_W), .CMD_W(CMD_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .vec2_req   (vec2_req),
    .ie_clr     (ie_clr),
    .cmd_wr     (cmd_wr),
    .cmd_data   (cmd_data),
    .ack        (ack),
    .irq_valid  (irq_valid),
    .irq_vector (irq_vector),
    .irq_nonvec (irq_nonvec),
    .status     (status)
);

// File: tb/irq_arbiter_bench.sv
module irq_arbiter_bench;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic nmi_req = 0, vec2_req = 0, vec1_req = 0, vec0_req = 0, ext_req = 0;
    logic ie_set = 0, ie_clr = 0, cmd_wr = 0, sample = 0, ack = 0;
    logic [4:0]  cmd_data = '0;
    logic        irq_valid, irq_nonvec;
    logic [15:0] irq_vector;
    logic [7:0]  status;

    int checks = 0;
    int fails  = 0;
    string phase = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_arbiter u_irq_arbiter (
        .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .vec2_req(vec2_req),
        .vec1_req(vec1_req), .vec0_req(vec0_req), .ext_req(ext_req),
        .ie_set(ie_set), .ie_clr(ie_clr), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
        .sample(sample), .ack(ack), .irq_valid(irq_valid),
        .irq_vector(irq_vector), .irq_nonvec(irq_nonvec), .status(status)
    );

    // ---------------- behavioural reference model ----------------
    bit [2:0] m_mask;
    bit m_ie, m_pend, m_prev, m_offer;
    int m_tq;   // 0 waiting for low, 1 low seen, 2 qualified
    int m_src;  // 0 trap, 1 high, 2 middle, 3 low, 4 external

    function automatic int m_winner();
        if (m_tq == 2 && nmi_req)                 return 0;
        if (m_ie && m_pend && !m_mask[2])         return 1;
        if (m_ie && vec1_req && !m_mask[1])       return 2;
        if (m_ie && vec0_req && !m_mask[0])       return 3;
        if (m_ie && ext_req)                      return 4;
        return -1;
    endfunction

    function automatic logic [15:0] m_vec(int s);
        case (s)
            0: return 16'h0024;
            1: return 16'h003C;
            2: return 16'h0034;
            3: return 16'h002C;
            default: return 16'h0000;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        int w;
        bit done, take, clrp, rise;
        if (!rst_n) begin
            m_mask = 3'b111; m_ie = 0; m_pend = 0; m_prev = 0;
            m_offer = 0; m_tq = 0; m_src = 4;
        end else begin
            w    = m_winner();
            done = m_offer && ack;
            take = !m_offer && sample && (w >= 0);
            if (ie_clr || (done && m_src != 0)) m_ie = 0;
            else if (ie_set)                    m_ie = 1;
            if (cmd_wr && cmd_data[3]) m_mask = cmd_data[2:0];
            rise   = vec2_req && !m_prev;
            clrp   = (cmd_wr && cmd_data[4]) || (done && m_src == 1);
            m_pend = rise || (m_pend && !clrp);
            m_prev = vec2_req;
            if (done && m_src == 0) m_tq = 0;
            else if (m_tq == 0 && !nmi_req) m_tq = 1;
            else if (m_tq == 1 && nmi_req)  m_tq = 2;
            else if (m_tq == 2 && !nmi_req) m_tq = 1;
            if (take) begin m_offer = 1; m_src = w; end
            else if (done) m_offer = 0;
        end
    end

    // compare on every falling edge, before inputs move
    always @(negedge clk) begin
        logic [15:0] ev;
        logic [7:0]  es;
        if (rst_n) begin
            ev = m_offer ? m_vec(m_src) : 16'h0;
            es = {1'b0, m_pend, vec1_req, vec0_req, m_ie, m_mask};
            checks++;
            if (irq_valid !== m_offer || irq_vector !== ev ||
                irq_nonvec !== (m_offer && m_src == 4) || status !== es) begin
                fails++;
                $display("FAIL %s model: valid=%0b vec=%h nonvec=%0b status=%h expected valid=%0b vec=%h nonvec=%0b status=%h",
                         phase, irq_valid, irq_vector, irq_nonvec, status,
                         m_offer, ev, (m_offer && m_src == 4), es);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic pulse_ie();
        ie_set = 1; step(1); ie_set = 0;
    endtask

    task automatic do_sample();
        sample = 1; step(1); sample = 0;
    endtask

    task automatic do_ack();
        ack = 1; step(1); ack = 0;
    endtask

    task automatic write_cmd(logic [4:0] d);
        cmd_wr = 1; cmd_data = d; step(1); cmd_wr = 0; cmd_data = '0;
    endtask

    bit finished = 0;

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual=running expected=done");
            summary();
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        step(3);
        rst_n = 1;
        step(1);

        phase = "R1";
        check("R1 valid", 32'(irq_valid), 0);
        check("R1 status", 32'(status), 32'h07);

        phase = "R2";
        pulse_ie();
        check("R2 set", 32'(status[3]), 1);
        ie_set = 1; ie_clr = 1; step(1); ie_set = 0; ie_clr = 0;
        check("R2 clear wins", 32'(status[3]), 0);
        pulse_ie();
        check("R2 set again", 32'(status[3]), 1);

        phase = "R3";
        write_cmd(5'h0A);
        check("R3 load", 32'(status[2:0]), 2);
        write_cmd(5'h05);
        check("R3 keep", 32'(status[2:0]), 2);

        phase = "R12";
        write_cmd(5'h0F);
        ext_req = 1;
        do_sample();
        check("R12 valid", 32'(irq_valid), 1);
        check("R9 nonvec", 32'(irq_nonvec), 1);
        check("R9 nonvec vector", 32'(irq_vector), 0);
        phase = "R10";
        do_sample();
        check("R10 held", 32'(irq_valid), 1);
        do_ack();
        check("R10 released", 32'(irq_valid), 0);
        check("R11 enable dropped", 32'(status[3]), 0);
        phase = "R12";
        do_sample();
        check("R12 gated by enable", 32'(irq_valid), 0);
        ext_req = 0;

        phase = "R6";
        pulse_ie();
        write_cmd(5'h08);
        vec0_req = 1; step(1); vec0_req = 0;
        do_sample();
        check("R6 level gone", 32'(irq_valid), 0);
        vec0_req = 1;
        do_sample();
        check("R6 level vector", 32'(irq_vector), 32'h002C);
        do_ack();
        vec0_req = 0;

        phase = "R5";
        pulse_ie();
        vec2_req = 1; step(1); vec2_req = 0;
        step(3);
        check("R5 pending held", 32'(status[6]), 1);
        do_sample();
        check("R9 high vector", 32'(irq_vector), 32'h003C);
        do_ack();
        check("R11 pending cleared", 32'(status[6]), 0);
        check("R11 enable dropped", 32'(status[3]), 0);
        vec2_req = 1; step(1);
        check("R5 new edge", 32'(status[6]), 1);
        phase = "R4";
        write_cmd(5'h10);
        step(2);
        check("R4 cleared, no re-set while high", 32'(status[6]), 0);
        check("R4 masks kept", 32'(status[2:0]), 0);
        vec2_req = 0; step(1);

        phase = "R8";
        pulse_ie();
        vec2_req = 1; step(1); vec2_req = 0;
        vec1_req = 1; vec0_req = 1; ext_req = 1;
        do_sample();
        check("R8 high first", 32'(irq_vector), 32'h003C);
        do_ack(); pulse_ie();
        do_sample();
        check("R8 middle next", 32'(irq_vector), 32'h0034);
        do_ack();
        vec1_req = 0; pulse_ie();
        do_sample();
        check("R8 low next", 32'(irq_vector), 32'h002C);
        do_ack();
        write_cmd(5'h09); pulse_ie();
        do_sample();
        check("R12 external ignores masks", 32'(irq_nonvec), 1);
        do_ack();
        vec0_req = 0; ext_req = 0;

        phase = "R7";
        nmi_req = 1; step(1);
        do_sample();
        check("R7 trap with enable off", 32'(irq_vector), 32'h0024);
        do_ack();
        check("R11 trap keeps enable", 32'(status[3]), 0);
        do_sample();
        check("R7 no retrigger while high", 32'(irq_valid), 0);
        nmi_req = 0; step(1); nmi_req = 1; step(1);
        do_sample();
        check("R7 retrigger after low", 32'(irq_vector), 32'h0024);
        do_ack();
        nmi_req = 0; step(1); nmi_req = 1; step(1); nmi_req = 0; step(1);
        do_sample();
        check("R7 short pulse ignored", 32'(irq_valid), 0);

        phase = "R8";
        pulse_ie();
        ext_req = 1; nmi_req = 1; step(1);
        do_sample();
        check("R8 trap beats all", 32'(irq_vector), 32'h0024);
        do_ack();
        check("R11 trap ack keeps enable", 32'(status[3]), 1);
        nmi_req = 0;
        do_sample();
        check("R8 external after trap", 32'(irq_nonvec), 1);
        do_ack();
        ext_req = 0;

        phase = "R10";
        do_ack();
        check("R10 stray ack", 32'(irq_valid), 0);

        step(2);
        finished = 1;
        summary();
    end

endmodule